// File: doc/BRIEF.md
# Salsa20/8 XOR Mixing Core

This core takes two 512-bit blocks, each viewed as sixteen 32-bit words, and runs the XOR-then-mix primitive used inside memory-hard key derivation. On acceptance it XORs the second block into the first and keeps the result twice: once as the working state and once as a saved copy. The working state then goes through eight add-rotate-XOR rounds, arranged as four double rounds. Each double round is a column pass followed by a row pass. At the end the saved copy is added word by word into the working state to form the result.

The core is iterative. Each cycle it performs one step of a pass, which is four independent quarter updates evaluated in parallel. A job therefore takes a fixed 34 cycles: one to load, thirty-two to mix and one for the final addition. Input uses a valid/ready pair. `in_valid` is taken only while `in_ready` is high, and `in_ready` stays low for the whole job, so a source that sees `in_ready` low must hold its block. The output has no back-pressure. `out_valid` pulses for one cycle, and `out_data` holds that result until the next job completes. The number of double rounds is a parameter, with a default of 4.

Top module: `salsa_xor_core`

## Requirements
- R1: On acceptance (`in_valid && in_ready` at a rising edge), word i of the working state and word i of the saved copy both become `in_a[32i+31:32i] ^ in_b[32i+31:32i]`, for i = 0..15. Word 0 sits in the least significant bits.
- R2: Every update has the form `t = t ^ rotl32(p + q, r)`. The addition is modulo 2^32 and the rotation is to the left by r bits.
- R3: A column pass works on the quartets (0,4,8,12), (5,9,13,1), (10,14,2,6) and (15,3,7,11). Its four steps use rotations 7, 9, 13 and 18. Step s updates the quartet element s+1 (mod 4) from elements s and s+3 (mod 4).
- R4: A row pass uses the same step rule and rotations on the quartets (0,1,2,3), (5,6,7,4), (10,11,8,9) and (15,12,13,14).
- R5: Four double rounds, each a column pass followed by a row pass, are applied in sequence, for eight rounds in total.
- R6: Result word i equals saved word i plus final working word i, modulo 2^32. An all-zero input gives an all-zero result.
- R7: `out_valid` rises 34 rising edges after the accepting edge, counting the accepting edge as the first.
- R8: `in_ready` is high when idle and low from the edge after acceptance until the result appears. Any `in_valid` while `in_ready` is low is ignored and does not disturb the running job.
- R9: `out_valid` is high for exactly one cycle per job.
- R10: `out_data` changes only on the edge that raises `out_valid`, and it holds its value until then.
- R11: After reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input blocks are valid |
| in_ready | output | 1 | Core is idle and will accept a job |
| in_a | input | 512 | First block, word i at bits 32i+31:32i |
| in_b | input | 512 | Second block, XORed into the first |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | 512 | Result block, held until the next result |

## Verification
Every result is due exactly 34 edges after the edge that accepts its job. The bench drives and samples on the falling edge and counts falling edges from the acceptance. It expects `out_valid` on the 34th count and compares `out_data` there against an arithmetic model built from the quartet tables. It checks that `out_valid` has dropped on the next falling edge, and it samples `out_data` again three cycles later to confirm the value held. During one job it raises `in_valid` with unrelated data in the middle of the mixing steps, checks that `in_ready` reads low at that point, and confirms that the result still matches the original inputs.

// File: rtl/salsa_mix_pkg.sv
package salsa_mix_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 16;
  localparam int LANES     = 4;
  localparam int IDX_W     = $clog2(NUM_WORDS);
  localparam int STEPS_PER_PASS = 4;

  typedef logic [WORD_W-1:0]           word_t;
  typedef word_t [NUM_WORDS-1:0]       block_t;
  typedef logic [IDX_W-1:0]            idx_t;

  // rotation per step within a pass; the order is part of the algorithm
  function automatic logic [4:0] rot_amt(input logic [1:0] step);
    case (step)
      2'd0:    return 5'd7;
      2'd1:    return 5'd9;
      2'd2:    return 5'd13;
      default: return 5'd18;
    endcase
  endfunction

  // element k of quartet `lane`, for a column pass or a row pass
  function automatic idx_t quartet_idx(input logic row_pass, input logic [1:0] lane,
                                       input logic [1:0] k);
    logic [1:0] diag;
    if (row_pass) begin
      diag = lane + k;
      return {lane, diag};
    end
    return idx_t'({2'b00, lane} * 4'd5 + {k, 2'b00});
  endfunction
endpackage

// File: rtl/salsa_lane.sv
module salsa_lane
  import salsa_mix_pkg::*;
(
  input  word_t      tgt,
  input  word_t      p,
  input  word_t      q,
  input  logic [4:0] rot,
  output word_t      res
);
  word_t sum;
  word_t rolled;

  always_comb begin
    sum    = p + q;
    rolled = (sum << rot) | (sum >> (6'd32 - {1'b0, rot}));
    res    = tgt ^ rolled;
  end
endmodule

// File: rtl/salsa_mix_step.sv
module salsa_mix_step
  import salsa_mix_pkg::*;
(
  input  block_t     cur,
  input  logic       row_pass,
  input  logic [1:0] step,
  output block_t     nxt
);
  idx_t  tgt_idx  [LANES];
  word_t lane_res [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    idx_t p_idx;
    idx_t q_idx;
    assign tgt_idx[g] = quartet_idx(row_pass, 2'(g), step + 2'd1);
    assign p_idx      = quartet_idx(row_pass, 2'(g), step);
    assign q_idx      = quartet_idx(row_pass, 2'(g), step + 2'd3);

    salsa_lane u_lane (
      .tgt (cur[tgt_idx[g]]),
      .p   (cur[p_idx]),
      .q   (cur[q_idx]),
      .rot (rot_amt(step)),
      .res (lane_res[g])
    );
  end

  always_comb begin
    nxt = cur;
    for (int l = 0; l < LANES; l++) nxt[tgt_idx[l]] = lane_res[l];
  end
endmodule

// File: rtl/salsa_seq.sv
module salsa_seq #(
  parameter int DOUBLE_ROUNDS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  output logic       load,
  output logic       mix_en,
  output logic       fin,
  output logic       row_pass,
  output logic [1:0] step
);
  localparam int TOTAL_STEPS = DOUBLE_ROUNDS * 2 * salsa_mix_pkg::STEPS_PER_PASS;
  localparam int CNT_W       = $clog2(TOTAL_STEPS);

  typedef enum logic [1:0] {S_IDLE, S_MIX, S_FIN} seq_state_e;

  seq_state_e       st;
  logic [CNT_W-1:0] cnt;

  assign in_ready = (st == S_IDLE);
  assign load     = in_ready && in_valid;
  assign mix_en   = (st == S_MIX);
  assign fin      = (st == S_FIN);
  assign step     = cnt[1:0];
  assign row_pass = cnt[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          st  <= S_MIX;
          cnt <= '0;
        end
        S_MIX: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(TOTAL_STEPS - 1)) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/salsa_xor_core.sv
module salsa_xor_core #(
  parameter int DOUBLE_ROUNDS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [511:0] in_a,
  input  logic [511:0] in_b,
  output logic         out_valid,
  output logic [511:0] out_data
);
  import salsa_mix_pkg::*;

  block_t     work_q;
  block_t     saved_q;
  block_t     work_nxt;
  block_t     sum_blk;
  logic       load;
  logic       mix_en;
  logic       fin;
  logic       row_pass;
  logic [1:0] step;

  salsa_seq #(.DOUBLE_ROUNDS(DOUBLE_ROUNDS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .load     (load),
    .mix_en   (mix_en),
    .fin      (fin),
    .row_pass (row_pass),
    .step     (step)
  );

  salsa_mix_step u_step (
    .cur      (work_q),
    .row_pass (row_pass),
    .step     (step),
    .nxt      (work_nxt)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_sum
    assign sum_blk[w] = saved_q[w] + work_q[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q    <= '0;
      saved_q   <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= fin;
      if (load) begin
        work_q  <= block_t'(in_a ^ in_b);
        saved_q <= block_t'(in_a ^ in_b);
      end else if (mix_en) begin
        work_q <= work_nxt;
      end
      if (fin) out_data <= sum_blk;
    end
  end
endmodule

// File: rtl/salsa_xor_core_chk.sv
module salsa_xor_core_chk #(
  parameter int DOUBLE_ROUNDS = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic [511:0] out_data
);
  localparam int LATENCY = 2 + DOUBLE_ROUNDS * 8;
  localparam int LAT_W   = $clog2(LATENCY + 1) + 1;

  logic [LAT_W-1:0] lat_cnt;
  logic             accept;

  assign accept = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lat_cnt <= '0;
    else if (accept)           lat_cnt <= LAT_W'(1);
    else if (out_valid)        lat_cnt <= '0;
    else if (lat_cnt != '0)    lat_cnt <= lat_cnt + 1'b1;
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (lat_cnt == LAT_W'(LATENCY))); // R7

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready); // R8

  AST_READY_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> out_valid); // R8

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R9

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_data) |-> out_valid); // R10
endmodule

bind salsa_xor_core salsa_xor_core_chk #(.DOUBLE_ROUNDS(DOUBLE_ROUNDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/test_salsa_xor_core.sv
`timescale 1ns/1ps
module test_salsa_xor_core;
  localparam int EXP_LAT = 34;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [511:0] in_a = '0;
  logic [511:0] in_b = '0;
  logic         out_valid;
  logic [511:0] out_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  salsa_xor_core i_salsa_xor_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic logic [31:0] rl(input logic [31:0] v, input int r);
    return (v << r) | (v >> (32 - r));
  endfunction

  function automatic void qr(inout logic [31:0] a, inout logic [31:0] b,
                             inout logic [31:0] c, inout logic [31:0] d);
    b ^= rl(a + d, 7);
    c ^= rl(b + a, 9);
    d ^= rl(c + b, 13);
    a ^= rl(d + c, 18);
  endfunction

  // R1..R6 arithmetic model from the quartet tables
  function automatic logic [511:0] model(input logic [511:0] a, input logic [511:0] b);
    logic [31:0] x [16];
    logic [31:0] s [16];
    logic [511:0] r;
    for (int i = 0; i < 16; i++) begin
      s[i] = a[32*i +: 32] ^ b[32*i +: 32];
      x[i] = s[i];
    end
    for (int d = 0; d < 4; d++) begin
      qr(x[0],  x[4],  x[8],  x[12]);
      qr(x[5],  x[9],  x[13], x[1]);
      qr(x[10], x[14], x[2],  x[6]);
      qr(x[15], x[3],  x[7],  x[11]);
      qr(x[0],  x[1],  x[2],  x[3]);
      qr(x[5],  x[6],  x[7],  x[4]);
      qr(x[10], x[11], x[8],  x[9]);
      qr(x[15], x[12], x[13], x[14]);
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = s[i] + x[i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [511:0] act,
                     input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic run(input logic [511:0] a, input logic [511:0] b, input bit poke,
                     input string tag);
    int lat;
    logic [511:0] exp;
    logic [511:0] got;
    exp = model(a, b);
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 idle ready", 512'(in_ready), 512'(1));
    in_a = a; in_b = b; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 100) begin
      if (poke && lat == 5) begin
        chk(in_ready == 1'b0, "R8 busy not ready", 512'(in_ready), 512'(0));
        in_a = ~a; in_b = rnd512(); in_valid = 1'b1;
      end
      if (poke && lat == 8) in_valid = 1'b0;
      @(negedge clk);
      lat++;
    end
    chk(lat == EXP_LAT, "R7 latency", 512'(lat), 512'(EXP_LAT));
    chk(out_data == exp, tag, out_data, exp);
    got = out_data;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 single pulse", 512'(out_valid), 512'(0));
    repeat (3) @(negedge clk);
    chk(out_data == got, "R10 output held", out_data, got);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [511:0] v;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(in_ready == 1'b1, "R11 ready in reset", 512'(in_ready), 512'(1));
    chk(out_valid == 1'b0, "R11 valid in reset", 512'(out_valid), 512'(0));
    chk(out_data == '0, "R11 data in reset", out_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_data == '0, "R11 after release", out_data, '0);

    // R6 all-zero input gives zero
    run('0, '0, 1'b0, "R6 zero input");
    // R1 equal blocks cancel, result is zero
    v = rnd512();
    run(v, v, 1'b0, "R1 xor cancel");
    chk(out_data == '0, "R1 cancel to zero", out_data, '0);
    // R3 R4 R5 single-word sweeps on each operand
    for (int i = 0; i < 16; i++) begin
      v = '0;
      v[32*i + (i % 32)] = 1'b1;
      run(v, '0, 1'b0, "R3 R4 R5 one-hot a");
      run('0, v, 1'b0, "R2 R5 one-hot b");
    end
    // all ones exercises carries in R2
    run({512{1'b1}}, '0, 1'b0, "R2 all ones");
    // R8 ignore input while busy
    run(rnd512(), rnd512(), 1'b1, "R8 ignored mid-job");
    // random jobs, R6 final add
    for (int k = 0; k < 24; k++) run(rnd512(), rnd512(), k % 5 == 0, "R6 random");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule